// File: doc/BRIEF.md
# Watchdog Timer with Pretimeout Interrupt

This block is a watchdog timer with five 16-bit registers on a simple write bus with a combinational read port. Once software enables it, an 8-bit count runs down by one on each 2 Hz `tick` strobe. A programmed timeout value N gives N+1 half-second steps before expiry. Software keeps the system alive by writing 0x5555 and then 0xAAAA to the service register. That pair reloads the count from the timeout field.

On expiry the block raises either the internal reset request or the active-low external reset line, depending on a control bit. The chosen output stays asserted for a fixed number of ticks. A pretimeout status flag can raise an interrupt a programmable number of half-seconds before expiry. Software can also request either reset directly.

A timeout-cause flag lives in the power-on domain, so it survives the warm reset that the watchdog itself triggers. A power-down counter pulses the external reset line after a delay unless software disables it.

Register map (byte offsets, decoded from `bus_addr`): 0x0 control, 0x2 service, 0x4 reset status, 0x6 interrupt control, 0x8 miscellaneous.

Top module: `wdog_timer`

## Requirements
- R1: After power-on reset, control reads 0x0030, interrupt control 0x0000, miscellaneous 0x0001 and status 0x0000. `int_rst` is 0, `ext_rst_n` is 1 and `irq` is 0.
- R2: With control bit 2 set and bits 15:8 = N, `int_rst` stays 0 through N ticks and rises on tick N+1. The count starts from the moment bit 2 is first written 1.
- R3: Writing 0x5555 and then 0xAAAA to offset 0x2 reloads the count to N, so the next expiry is N+1 ticks after the second word.
- R4: No reload happens if any other write comes between the two service words (to any offset, with any value), or if the second word is not 0xAAAA.
- R5: Control bit 2 (enable) cannot be cleared by software once set.
- R6: Control bit 0 (suspend) takes its value from the first control write after reset, and later writes leave it unchanged. While bit 0 and the `lowpower` input are both 1, ticks do not advance the count.
- R7: With control bit 3 = 1, expiry pulls `ext_rst_n` low and leaves `int_rst` at 0.
- R8: Each reset output stays asserted for HOLD_TICKS ticks after its trigger.
- R9: A control write with bit 4 = 0 asserts `int_rst`, and one with bit 5 = 0 asserts `ext_rst_n` low. Both bits always read back as 1.
- R10: Status bit 1 at offset 0x4 is set by expiry. It survives a warm reset (`rst_n`), is cleared by a software internal reset request, and is cleared by `por_n`.
- R11: At offset 0x6, bits 7:0 = P. Status bit 14 sets on tick N+1-P after a reload, whether or not the interrupt is enabled. `irq` is bit 14 AND enable bit 15. Writing 1 to bit 14 clears it.
- R12: A timeout value written while the watchdog runs takes effect only at the next reload.
- R13: If bit 0 at offset 0x8 is still 1 when PD_TICKS ticks have passed since reset, `ext_rst_n` goes low for exactly one clock. Writing 0 to that bit prevents the pulse, and writing 1 cannot set it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| rst_n | input | 1 | Warm reset, active low, spares status and output holds |
| tick | input | 1 | One-cycle 2 Hz strobe from the slow clock |
| lowpower | input | 1 | System is in low-power mode |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| int_rst | output | 1 | Internal reset request, active high |
| ext_rst_n | output | 1 | External reset, active low |
| irq | output | 1 | Pretimeout interrupt |

## Verification
The bench builds the block with HOLD_TICKS = 3 and PD_TICKS = 10, so output hold windows and the power-down pulse fall within a few dozen cycles. Timeout values of 2 to 9 place expiry, pretimeout and reload effects on exact, countable ticks. With these values both sides of every boundary can be checked: tick N against N+1, the hold's last tick against the one after, and the tick before the power-down pulse against the pulse itself.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int HOLD_TICKS = 4,
  parameter int PD_TICKS   = 32
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        lowpower,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        int_rst,
  output logic        ext_rst_n,
  output logic        irq
);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam int PW = $clog2(PD_TICKS + 1);
  localparam logic [3:0] A_CTRL = 4'h0, A_SVC = 4'h2, A_STAT = 4'h4, A_ICR = 4'h6, A_MISC = 4'h8;
  localparam logic [15:0] KEY1 = 16'h5555, KEY2 = 16'hAAAA;

  logic [7:0]    tmo, cnt, pre;
  logic          act, en, susp, lock, armed, ien, ists, pd_en, pd_pulse, tout;
  logic [HW-1:0] ihold, ehold;
  logic [PW-1:0] pd_cnt;

  logic wr_ctrl, wr_svc, wr_icr, wr_misc;
  logic step, expire, svc_ok, start, reload, sw_int, sw_ext, trig_int, trig_ext;

  assign wr_ctrl  = bus_we && bus_addr == A_CTRL;
  assign wr_svc   = bus_we && bus_addr == A_SVC;
  assign wr_icr   = bus_we && bus_addr == A_ICR;
  assign wr_misc  = bus_we && bus_addr == A_MISC;
  assign step     = tick && en && !(susp && lowpower);
  assign expire   = step && cnt == 8'd0;
  assign svc_ok   = wr_svc && armed && bus_wdata == KEY2;
  assign start    = wr_ctrl && !en && bus_wdata[2];
  assign reload   = svc_ok || start;
  assign sw_int   = wr_ctrl && !bus_wdata[4];
  assign sw_ext   = wr_ctrl && !bus_wdata[5];
  assign trig_int = (expire && !act) || sw_int;
  assign trig_ext = (expire && act) || sw_ext;

  // control register, warm domain
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tmo <= '0; act <= 1'b0; en <= 1'b0; susp <= 1'b0; lock <= 1'b0;
    end else if (wr_ctrl) begin
      tmo  <= bus_wdata[15:8];
      act  <= bus_wdata[3];
      en   <= en | bus_wdata[2];
      lock <= 1'b1;
      if (!lock) susp <= bus_wdata[0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        cnt <= '0;
    else if (reload)   cnt <= start ? bus_wdata[15:8] : tmo;
    else if (expire)   cnt <= tmo;
    else if (step)     cnt <= cnt - 8'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      armed <= 1'b0;
    else if (bus_we) armed <= wr_svc && bus_wdata == KEY1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ien <= 1'b0; pre <= '0; ists <= 1'b0;
    end else begin
      if (wr_icr) begin
        ien <= bus_wdata[15];
        pre <= bus_wdata[7:0];
      end
      if (step && cnt == pre)          ists <= 1'b1;
      else if (wr_icr && bus_wdata[14]) ists <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pd_en <= 1'b1; pd_cnt <= '0; pd_pulse <= 1'b0;
    end else begin
      if (wr_misc && !bus_wdata[0]) pd_en <= 1'b0;
      if (tick && pd_cnt != PW'(PD_TICKS)) pd_cnt <= pd_cnt + 1'b1;
      pd_pulse <= tick && pd_en && pd_cnt == PW'(PD_TICKS - 1);
    end

  // holds and cause flag, power-on domain
  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      ihold <= '0; ehold <= '0; tout <= 1'b0;
    end else begin
      if (trig_int)                 ihold <= HW'(HOLD_TICKS);
      else if (tick && ihold != '0) ihold <= ihold - 1'b1;
      if (trig_ext)                 ehold <= HW'(HOLD_TICKS);
      else if (tick && ehold != '0) ehold <= ehold - 1'b1;
      if (expire)      tout <= 1'b1;
      else if (sw_int) tout <= 1'b0;
    end

  assign int_rst   = ihold != '0;
  assign ext_rst_n = !(ehold != '0 || pd_pulse);
  assign irq       = ien && ists;

  always_comb
    case (bus_addr)
      A_CTRL:  bus_rdata = {tmo, 2'b00, 2'b11, act, en, 1'b0, susp};
      A_STAT:  bus_rdata = {14'd0, tout, 1'b0};
      A_ICR:   bus_rdata = {ien, ists, 6'd0, pre};
      A_MISC:  bus_rdata = {15'd0, pd_en};
      default: bus_rdata = 16'h0000;
    endcase

  a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt != 8'd0 && !reload) |=> cnt == $past(cnt) - 8'd1);
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_svc && armed && bus_wdata == KEY2) |=> cnt == $past(tmo));
  a_r5_en_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);
  a_r6_susp_locked: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(susp));
  a_r8_hold_on_tick: assert property (@(posedge clk) disable iff (!por_n)
    $fell(int_rst) |-> $past(tick));
  a_r11_pre_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ists) |-> $past(tick));
  a_r13_pd_one_clk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_pulse |=> !pd_pulse);
endmodule

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b0, tick = 1'b0, lowpower = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic int_rst, ext_rst_n, irq;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  wdog_timer #(.HOLD_TICKS(3), .PD_TICKS(10)) u_wdog_timer (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick(tick), .lowpower(lowpower),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .int_rst(int_rst), .ext_rst_n(ext_rst_n), .irq(irq));

  // {addr, write data, expected readback}; covers R5 R6 R9 R11 R13 register behaviour
  localparam logic [35:0] VEC [0:9] = '{
    36'h0_0531_0531, 36'h0_0734_0735, 36'h0_0A30_0A35, 36'h6_8003_8003, 36'h6_0004_0004,
    36'h8_0001_0001, 36'h8_0000_0000, 36'h2_1234_0000, 36'h4_FFFF_0000, 36'h0_0A38_0A3D};

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rdchk(input string tag, input logic [3:0] a, input logic [15:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(posedge clk); @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic full_reset();
    por_n = 1'b0; rst_n = 1'b0; lowpower = 1'b0; tick = 1'b0; bus_we = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic fresh(); full_reset(); wr(4'h8, 16'h0000); endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    full_reset();
    rdchk("R1 ctrl", 4'h0, 16'h0030);
    rdchk("R1 icr", 4'h6, 16'h0000);
    rdchk("R1 misc", 4'h8, 16'h0001);
    rdchk("R1 stat", 4'h4, 16'h0000);
    chk("R1 outputs", {13'd0, int_rst, ext_rst_n, irq}, 16'h0002);

    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][35:32], VEC[i][31:16]);
      rdchk($sformatf("R5/R6/R9/R11/R13 table %0d", i), VEC[i][35:32], VEC[i][15:0]);
    end

    // R2 expiry, R8 hold, R10 cause flag
    fresh();
    wr(4'h0, 16'h0534);
    ticks(5); chk("R2 before expiry", {15'd0, int_rst}, 16'd0);
    ticks(1); chk("R2 expiry int", {15'd0, int_rst}, 16'd1);
    chk("R2 ext idle", {15'd0, ext_rst_n}, 16'd1);
    ticks(2); chk("R8 still held", {15'd0, int_rst}, 16'd1);
    ticks(1); chk("R8 released", {15'd0, int_rst}, 16'd0);
    rdchk("R10 flag set", 4'h4, 16'h0002);
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1; @(negedge clk);
    rdchk("R10 survives warm", 4'h4, 16'h0002);
    rdchk("R10 ctrl warm cleared", 4'h0, 16'h0030);
    wr(4'h0, 16'h0020);
    chk("R9 sw int", {15'd0, int_rst}, 16'd1);
    chk("R9 sw int no ext", {15'd0, ext_rst_n}, 16'd1);
    rdchk("R9 bits read 1", 4'h0, 16'h0030);
    rdchk("R10 cleared by sw", 4'h4, 16'h0000);
    fresh(); wr(4'h0, 16'h0534); ticks(6);
    full_reset();
    rdchk("R10 cleared by por", 4'h4, 16'h0000);

    // R3 service reload
    fresh(); wr(4'h0, 16'h0434); ticks(3);
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    ticks(4); chk("R3 reloaded", {15'd0, int_rst}, 16'd0);
    ticks(1); chk("R3 expiry after reload", {15'd0, int_rst}, 16'd1);

    // R4 broken sequences
    fresh(); wr(4'h0, 16'h0434); ticks(3);
    wr(4'h2, 16'h5555); wr(4'h6, 16'h0000); wr(4'h2, 16'hAAAA);
    ticks(1); chk("R4 other reg between", {15'd0, int_rst}, 16'd0);
    ticks(1); chk("R4 other reg expiry", {15'd0, int_rst}, 16'd1);
    fresh(); wr(4'h0, 16'h0434); ticks(3);
    wr(4'h2, 16'h5555); wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA);
    ticks(2); chk("R4 value between", {15'd0, int_rst}, 16'd1);
    fresh(); wr(4'h0, 16'h0434); ticks(3);
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAB);
    ticks(2); chk("R4 wrong second", {15'd0, int_rst}, 16'd1);

    // R12 rewrite while running
    fresh(); wr(4'h0, 16'h0434); ticks(2);
    wr(4'h0, 16'h0934);
    ticks(2); chk("R12 old value pre", {15'd0, int_rst}, 16'd0);
    ticks(1); chk("R12 old value used", {15'd0, int_rst}, 16'd1);
    fresh(); wr(4'h0, 16'h0434); ticks(2);
    wr(4'h0, 16'h0934); wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    ticks(9); chk("R12 new value pre", {15'd0, int_rst}, 16'd0);
    ticks(1); chk("R12 new value used", {15'd0, int_rst}, 16'd1);

    // R7 external action
    fresh(); wr(4'h0, 16'h033C);
    ticks(3); chk("R7 before", {15'd0, ext_rst_n}, 16'd1);
    ticks(1); chk("R7 ext low", {15'd0, ext_rst_n}, 16'd0);
    chk("R7 int quiet", {15'd0, int_rst}, 16'd0);

    // R9 software external request
    fresh(); wr(4'h0, 16'h0010);
    chk("R9 sw ext", {15'd0, ext_rst_n}, 16'd0);
    chk("R9 sw ext no int", {15'd0, int_rst}, 16'd0);

    // R6 suspend in low power
    fresh(); wr(4'h0, 16'h0535);
    lowpower = 1'b1; ticks(10);
    chk("R6 frozen", {15'd0, int_rst}, 16'd0);
    lowpower = 1'b0; ticks(5);
    chk("R6 resumed pre", {15'd0, int_rst}, 16'd0);
    ticks(1); chk("R6 resumed expiry", {15'd0, int_rst}, 16'd1);

    // R11 pretimeout
    fresh(); wr(4'h6, 16'h8002); wr(4'h0, 16'h0534);
    ticks(3); chk("R11 irq early", {15'd0, irq}, 16'd0);
    ticks(1); chk("R11 irq set", {15'd0, irq}, 16'd1);
    rdchk("R11 status bit", 4'h6, 16'hC002);
    wr(4'h6, 16'hC002);
    chk("R11 irq cleared", {15'd0, irq}, 16'd0);
    rdchk("R11 status cleared", 4'h6, 16'h8002);
    fresh(); wr(4'h6, 16'h0001); wr(4'h0, 16'h0234);
    ticks(2); rdchk("R11 flag without enable", 4'h6, 16'h4001);
    chk("R11 no irq when disabled", {15'd0, irq}, 16'd0);

    // R13 power-down counter
    full_reset();
    ticks(9); chk("R13 before pulse", {15'd0, ext_rst_n}, 16'd1);
    ticks(1); chk("R13 pulse", {15'd0, ext_rst_n}, 16'd0);
    @(negedge clk); chk("R13 one clock", {15'd0, ext_rst_n}, 16'd1);
    fresh(); wr(4'h8, 16'h0001);
    rdchk("R13 cannot re-enable", 4'h8, 16'h0000);
    ticks(10); chk("R13 disabled", {15'd0, ext_rst_n}, 16'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule